// File: doc/BRIEF.md
# Prescaled programmable baud clock generator

This block derives the 16x oversampling enable pulse that paces a UART's transmitter and its receiver. Both sides take the same pulse. The reference clock passes first through a selectable prescaler, which either passes every cycle or only every fourth cycle. The result then feeds a 16-bit programmable divider.

Software loads the divisor as two bytes and sets the prescaler choice in a control byte. All of these go through a plain one-cycle register-write strobe. The output pulse runs at reference / prescale / divisor, so the divisor for a wanted baud rate is reference / (prescale × 16 × baud). A divisor of zero halts pulse generation completely, and a status flag shows whether the generator is active.

Both prescaler and divider are clock-enable counters in the reference clock domain, so no derived clock is made. Every accepted register write restarts both counters, so a new setting takes effect cleanly without a stray pulse.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the divisor is zero, the prescaler passes every cycle, `tick_o` is low and `running_o` is low.
- R2: A write to address 0 loads divisor bits 7:0 and a write to address 1 loads divisor bits 15:8. The two bytes form one 16-bit divisor.
- R3: A write to address 2 sets the prescaler from data bit 7: 0 means divide-by-1 and 1 means divide-by-4. With divide-by-4, the divider advances only on every fourth reference cycle.
- R4: With divisor D > 0 and prescale P, `tick_o` is high for one cycle out of every P·D reference cycles.
- R5: Each write to addresses 0, 1 or 2 restarts counting. The first following tick is high in the cycle after the P·D-th rising edge that follows the write edge, and no tick appears before it.
- R6: While the divisor is zero, `tick_o` stays low.
- R7: `running_o` is high exactly when the divisor is nonzero. It reflects a write from the cycle after the write edge.
- R8: With D = 1 and P = 1, `tick_o` is high on every cycle.
- R9: When P·D > 1, `tick_o` is never high on two consecutive cycles.
- R10: A write to address 3 changes nothing: the registers and the count phase are left alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register address: 0 divisor low, 1 divisor high, 2 control |
| wr_data | input | 8 | Write data; for control, bit 7 selects divide-by-4 |
| tick_o | output | 1 | 16x baud enable pulse, one cycle wide |
| running_o | output | 1 | High while the divisor is nonzero |

## Verification
The write edge is the reference point for every timed result. `running_o` is due one cycle after it. The first `tick_o` is due P·D cycles after it, because the tick is registered and both counters restart at that edge. Each later tick follows the previous one after exactly P·D cycles.

The bench drives inputs and samples outputs on falling edges. It counts falling edges from the one that ends the write and requires the first tick at exactly index P·D and the next one P·D later. A late tick and an early tick both show up as a mismatch of the index. Where the divisor is zero, the bench watches a long window and requires that no tick occurs in it.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef enum logic {
    PRE_BYPASS  = 1'b0,
    PRE_QUARTER = 1'b1
  } pre_sel_e;

endpackage

// File: rtl/baud_regs.sv
module baud_regs #(
  parameter int DIV_W   = 16,
  parameter int REG_W   = 8,
  parameter int ADDR_W  = 2,
  parameter int SEL_BIT = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [REG_W-1:0]     wr_data,
  output logic [DIV_W-1:0]     div_o,
  output baud_pkg::pre_sel_e   sel_o,
  output logic                 reload_o
);
  import baud_pkg::*;

  localparam int NBYTES   = DIV_W / REG_W;
  localparam int CTRL_IDX = NBYTES;

  logic ctrl_hit;
  assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(CTRL_IDX));

  // one byte register per divisor slice, addressed by its slice index
  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    logic [REG_W-1:0] byte_q;
    logic             hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(k));
    always_ff @(posedge clk) begin
      if (!rst_n)   byte_q <= '0;
      else if (hit) byte_q <= wr_data;
    end
    assign div_o[k*REG_W +: REG_W] = byte_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        sel_o <= PRE_BYPASS;
    else if (ctrl_hit) sel_o <= pre_sel_e'(wr_data[SEL_BIT]);
  end

  // any accepted address restarts counting; unused addresses are ignored
  assign reload_o = wr_en && (int'(wr_addr) <= CTRL_IDX);

endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int PRE_DIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reload_i,
  input  baud_pkg::pre_sel_e sel_i,
  output logic               en_o
);
  import baud_pkg::*;

  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  if (PRE_DIV > 1) begin : g_div
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
    logic [PRE_W-1:0] pcnt_q;

    always_ff @(posedge clk) begin
      if (!rst_n || reload_i)    pcnt_q <= '0;
      else if (pcnt_q == PRE_LAST) pcnt_q <= '0;
      else                       pcnt_q <= pcnt_q + 1'b1;
    end

    assign en_o = (sel_i == PRE_BYPASS) ? 1'b1 : (pcnt_q == PRE_LAST);

    // R3: with the slow prescale the enable is never back to back
    p_en_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_o && sel_i == PRE_QUARTER && !reload_i) |=> !en_o);
  end else begin : g_pass
    assign en_o = 1'b1;
  end

endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             tick_q;
  logic             at_end;

  assign at_end = (cnt_q == div_i - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || reload_i || div_i == '0) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (en_i) begin
      cnt_q  <= at_end ? '0 : cnt_q + 1'b1;
      tick_q <= at_end;
    end else begin
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  // R4: the running count always stays inside the programmed period
  p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i != '0) |-> (cnt_q < div_i));

  // R9: a pulse is followed by a low cycle unless the period is one cycle
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_q && !(en_i && div_i == DIV_W'(1))) |=> !tick_q);

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W   = 16,
  parameter int REG_W   = 8,
  parameter int ADDR_W  = 2,
  parameter int SEL_BIT = 7,
  parameter int PRE_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic              tick_o,
  output logic              running_o
);
  import baud_pkg::*;

  logic [DIV_W-1:0] div_w;
  pre_sel_e         sel_w;
  logic             reload_w;
  logic             en_w;

  baud_regs #(
    .DIV_W(DIV_W), .REG_W(REG_W), .ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .div_o(div_w), .sel_o(sel_w), .reload_o(reload_w)
  );

  baud_prescale #(.PRE_DIV(PRE_DIV)) pre_i (
    .clk(clk), .rst_n(rst_n), .reload_i(reload_w), .sel_i(sel_w), .en_o(en_w)
  );

  baud_divider #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst_n(rst_n), .reload_i(reload_w), .en_i(en_w),
    .div_i(div_w), .tick_o(tick_o)
  );

  assign running_o = (div_w != '0);

  // R6: a stopped generator emits nothing
  p_quiet_when_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |-> !tick_o);

  // R5: the edge after an accepted write never carries a pulse
  p_no_glitch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reload_w |=> !tick_o);

endmodule

// File: tb/baud_tick_gen_tb_top.sv
`timescale 1ns/1ps
module baud_tick_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick_o;
  logic       running_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  baud_tick_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick_o(tick_o), .running_o(running_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R4 watchdog: actual %0d cycles, expected fewer than 190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive at a falling edge, write edge follows, return at the next falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int exp_period(input int d, input bit quarter);
    return (d == 0) ? 0 : d * (quarter ? 4 : 1);
  endfunction

  task automatic cfg(input int d, input bit quarter);
    wr(2'd0, d[7:0]);
    wr(2'd1, d[15:8]);
    wr(2'd2, {quarter, 7'b0});
  endtask

  // falling edges since the last write edge: 'skip' already elapsed
  task automatic measure(input int exp, input int skip, input string tag);
    if (exp == 0) begin
      int seen = 0;
      for (int k = 0; k < 600; k++) begin
        @(negedge clk);
        if (tick_o) seen++;
      end
      chk(seen == 0, tag, seen, 0);
      chk(running_o == 1'b0, {tag, " running"}, running_o, 0);
    end else begin
      int first = 0;
      int gap = 0;
      for (int k = skip + 1; k <= exp; k++) begin
        @(negedge clk);
        if (tick_o && first == 0) first = k;
      end
      chk(first == exp, {tag, " first tick"}, first, exp);
      for (int k = 1; k <= exp + 2; k++) begin
        @(negedge clk);
        if (tick_o) begin gap = k; break; end
      end
      chk(gap == exp, {tag, " period"}, gap, exp);
      chk(running_o == 1'b1, {tag, " running"}, running_o, 1);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tick_o == 1'b0, "R1 tick after reset", tick_o, 0);
    chk(running_o == 1'b0, "R1 running after reset", running_o, 0);
    measure(0, 0, "R6 reset divisor zero");

    // default prescale is bypass: only the low byte is written
    wr(2'd0, 8'd3);
    measure(3, 0, "R1 default prescale");

    cfg(1, 1'b0);
    measure(1, 0, "R8 divisor one");
    cfg(1, 1'b1);
    measure(4, 0, "R3 quarter prescale");
    cfg(9, 1'b1);
    measure(exp_period(9, 1'b1), 0, "R3 quarter nine");
    cfg(16'h0100, 1'b0);
    measure(256, 0, "R2 high byte only");
    cfg(16'h0102, 1'b0);
    measure(258, 0, "R2 both bytes");

    for (int t = 0; t < 14; t++) begin
      int d;
      bit q;
      d = 1 + int'($urandom % 300);
      q = 1'($urandom % 2);
      cfg(d, q);
      measure(exp_period(d, q), 0, "R4 random");
    end

    cfg(0, 1'b0);
    measure(0, 0, "R6 divisor cleared");
    wr(2'd0, 8'd5);
    chk(running_o == 1'b1, "R7 running one cycle after write", running_o, 1);
    measure(5, 0, "R7 restart from zero");

    // R5: rewrite mid period restarts the count
    cfg(20, 1'b0);
    repeat (7) @(negedge clk);
    wr(2'd0, 8'd20);
    measure(20, 0, "R5 restart on rewrite");

    // R10: a write to address 3 leaves the phase and the period alone
    cfg(10, 1'b0);
    repeat (3) @(negedge clk);
    wr(2'd3, 8'hFF);
    measure(10, 5, "R10 unused address");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule